// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two-channel serial audio stream into a pair of signed 24-bit samples. It runs on a fast system clock and treats the bit clock, the frame (left/right) clock and the serial data line as ordinary inputs. It registers them, finds each rising edge of the bit clock, and shifts data in at those edges only. Each time the frame clock changes level, the half-frame that just ended is complete. The word carried in that half-frame is then taken out and left-aligned into 24 bits.

Five framings share a single shift path: 16-bit, 20-bit and 24-bit LSB-justified, 24-bit MSB-justified, and I2S. The framing in use is the bitwise OR of a 3-bit pin field and a 3-bit register field. After the right-channel word completes, both words are presented together with a one-cycle valid strobe. A sticky flag records any complete half-frame that carried fewer bit-clock edges than the selected framing needs.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `left_sample`, `right_sample`, `sample_valid` and `clk_short_err` are all zero.
- R2: The framing code in use is `fmt_pin | fmt_reg`, bit by bit. For example, pin 3'b001 with register 3'b010 selects code 3.
- R3: Code 0 (16-bit LSB-justified): the word is the last 16 bits sampled before a frame-clock change. It appears in bits 23:8 of the output, and bits 7:0 are zero.
- R4: Code 1 (20-bit LSB-justified): the word is the last 20 bits before the change. It appears in bits 23:4, and bits 3:0 are zero.
- R5: Code 4 (24-bit LSB-justified): the word is the last 24 bits sampled before the change.
- R6: Code 2 (24-bit MSB-justified, also used for codes 5 to 7): the word is the first 24 bits of the half-frame, starting with the bit sampled on the first rising bit-clock edge that sees the new frame-clock level. Later bits are ignored.
- R7: Code 3 (I2S): the MSB is sampled one bit-clock edge after the first edge of the half-frame, and frame clock low marks the left channel. In every other code, frame clock high marks the left channel.
- R8: In LSB-justified codes, bits that come before the word in a half-frame have no effect on the output.
- R9: `sample_valid` is high for exactly one cycle, 3 clock cycles after the rising bit-clock edge that opens the next left half-frame is presented at the pins. It comes with the left and right words of the frame that just ended, and it is never high on two cycles in a row.
- R10: `clk_short_err` is set, and stays set until reset, when a complete half-frame holds fewer rising bit-clock edges than 16 (code 0), 20 (code 1) or 24 (all other codes). The partial half-frame seen first after reset is never judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock; data is sampled at its rising edges |
| lrclk | input | 1 | Frame clock; its level selects the channel |
| sdata | input | 1 | Serial data, two's complement, MSB first |
| fmt_pin | input | 3 | Framing code from pins |
| fmt_reg | input | 3 | Framing code from a register |
| left_sample | output | 24 | Left sample, left-aligned |
| right_sample | output | 24 | Right sample, left-aligned |
| sample_valid | output | 1 | One-cycle strobe marking a new sample pair |
| clk_short_err | output | 1 | Sticky flag for a half-frame that was too short |

## Verification
A rising bit-clock edge driven at the pins takes one cycle to reach the input registers and one more to reach the word registers. The pair outputs follow on the third clock edge. The bench drives every pin change on a falling clock edge, well away from the active edge. In the latency scenario it samples `sample_valid` on the first four falling edges after the opening bit-clock rise: the strobe must be low, low, high, then low again. The other scenarios record each strobe on a falling edge and compare the captured words, and the error flag, only after the stream has gone quiet for several cycles.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  localparam int unsigned FMT_W = 3;

  // word length per framing code; also the minimum edges per half-frame
  function automatic int word_len(input logic [FMT_W-1:0] f);
    case (f)
      3'd0:    return 16;
      3'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic is_lsb_just(input logic [FMT_W-1:0] f);
    return (f == 3'd0) || (f == 3'd1) || (f == 3'd4);
  endfunction

  function automatic logic is_i2s(input logic [FMT_W-1:0] f);
    return f == 3'd3;
  endfunction
endpackage

// File: rtl/sarx_sampler.sv
module sarx_sampler (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdata,
  output logic rise,
  output logic lr,
  output logic sd
);
  logic bclk_q, bclk_qq, lr_q, sd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      lr_q    <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      bclk_q  <= bclk;
      bclk_qq <= bclk_q;
      lr_q    <= lrclk;
      sd_q    <= sdata;
    end
  end

  assign rise = bclk_q & ~bclk_qq;
  assign lr   = lr_q;
  assign sd   = sd_q;

  // edge strobe lasts one cycle (feeds R9 timing)
  p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise,
  input  logic                lr,
  input  logic                sd,
  input  logic [FMT_W-1:0]    fmt,
  output logic                word_done,
  output logic                word_left,
  output logic [SAMPLE_W-1:0] word,
  output logic                short_half
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                have_prev, lr_prev, synced;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] shreg;
  logic                boundary, left_lvl, shift_en;
  logic [CNT_W-1:0]    idx;
  int                  wl, start;
  logic [SAMPLE_W-1:0] aligned;

  always_comb begin
    wl       = word_len(fmt);
    start    = is_i2s(fmt) ? 1 : 0;
    left_lvl = !is_i2s(fmt);
    boundary = rise && have_prev && (lr != lr_prev);
    idx      = boundary ? '0 : cnt;
    shift_en = is_lsb_just(fmt) ||
               ((int'(idx) >= start) && (int'(idx) < start + wl));
    aligned  = shreg << (SAMPLE_W - wl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev  <= 1'b0;
      lr_prev    <= 1'b0;
      synced     <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      word_done  <= 1'b0;
      word_left  <= 1'b0;
      word       <= '0;
      short_half <= 1'b0;
    end else begin
      word_done  <= 1'b0;
      short_half <= 1'b0;
      if (rise) begin
        have_prev <= 1'b1;
        lr_prev   <= lr;
        if (boundary) begin
          if (synced) begin
            word_done  <= 1'b1;
            word       <= aligned;
            word_left  <= (lr_prev == left_lvl);
            short_half <= (int'(cnt) < wl);
          end
          synced <= 1'b1;
          cnt    <= {{(CNT_W-1){1'b0}}, 1'b1};
          shreg  <= shift_en ? {{(SAMPLE_W-1){1'b0}}, sd} : '0;
        end else begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (shift_en) shreg <= {shreg[SAMPLE_W-2:0], sd};
        end
      end
    end
  end

  // a finished word always follows a sampled bit-clock edge
  p_done_after_edge_r9: assert property (@(posedge clk) disable iff (rst)
    word_done |-> $past(rise));
endmodule

// File: rtl/sarx_pair.sv
module sarx_pair #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                word_done,
  input  logic                word_left,
  input  logic [SAMPLE_W-1:0] word,
  input  logic                short_half,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                valid,
  output logic                err
);
  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_out  <= '0;
      right_out <= '0;
      valid     <= 1'b0;
      err       <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (word_done && short_half) err <= 1'b1;
      if (word_done && word_left) begin
        left_hold <= word;
        have_left <= 1'b1;
      end else if (word_done && have_left) begin
        left_out  <= left_hold;
        right_out <= word;
        valid     <= 1'b1;
        have_left <= 1'b0;
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_valid_from_right_r9: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(word_done && !word_left));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                sdata,
  input  logic [2:0]          fmt_pin,
  input  logic [2:0]          fmt_reg,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid,
  output logic                clk_short_err
);
  logic                rise, lr, sd;
  logic [FMT_W-1:0]    fmt_eff;
  logic                word_done, word_left, short_half;
  logic [SAMPLE_W-1:0] word;

  assign fmt_eff = fmt_pin | fmt_reg;

  sarx_sampler u_smp (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .rise(rise), .lr(lr), .sd(sd)
  );

  sarx_deser #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_des (
    .clk(clk), .rst(rst), .rise(rise), .lr(lr), .sd(sd), .fmt(fmt_eff),
    .word_done(word_done), .word_left(word_left), .word(word),
    .short_half(short_half)
  );

  sarx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk(clk), .rst(rst), .word_done(word_done), .word_left(word_left),
    .word(word), .short_half(short_half), .left_out(left_sample),
    .right_out(right_sample), .valid(sample_valid), .err(clk_short_err)
  );
endmodule

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b1, lrclk = 1'b0, sdata = 1'b0;
  logic [2:0]  fmt_pin = 3'd0, fmt_reg = 3'd0;
  logic [23:0] left_sample, right_sample;
  logic        sample_valid, clk_short_err;

  int nchk = 0, nfail = 0, ncap = 0, cyc = 0;
  logic [23:0] cap_l [0:7];
  logic [23:0] cap_r [0:7];
  logic [23:0] exp_l [0:3];
  logic [23:0] exp_r [0:3];

  always #2.5 clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt_pin(fmt_pin), .fmt_reg(fmt_reg), .left_sample(left_sample),
    .right_sample(right_sample), .sample_valid(sample_valid),
    .clk_short_err(clk_short_err)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sample_valid && ncap < 8) begin
      cap_l[ncap] = left_sample;
      cap_r[ncap] = right_sample;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wlen(input logic [2:0] f);
    return (f == 3'd0) ? 16 : (f == 3'd1) ? 20 : 24;
  endfunction

  function automatic logic tx_bit(input logic [2:0] f, input int half,
                                  input logic [23:0] s, input int idx);
    int wl = wlen(f);
    int j;
    if (f == 3'd0 || f == 3'd1 || f == 3'd4) j = idx - (half - wl);
    else if (f == 3'd3) j = idx - 1;
    else j = idx;
    if (j >= 0 && j < wl) return s[23-j];
    return (idx % 3) != 0;  // filler outside the word
  endfunction

  task automatic do_reset(input logic right_lvl);
    rst = 1'b1; bclk = 1'b1; lrclk = right_lvl; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic play_half(input logic [2:0] f, input logic lvl,
                           input int half, input logic [23:0] s);
    for (int i = 0; i < half; i++) begin
      lrclk = lvl; sdata = tx_bit(f, half, s, i); bclk = 1'b0;
      repeat (2) @(negedge clk);
      bclk = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic gen_pairs(input logic [2:0] f);
    logic [23:0] mask = 24'hFFFFFF << (24 - wlen(f));
    for (int p = 0; p < 4; p++) begin
      exp_l[p] = ((24'h9A5C3F + 24'h31B7D * p) ^ {p[0], 23'h0}) & mask;
      exp_r[p] = ((24'h46E1A5 + 24'h2C903 * p) ^ {p[1], 23'h0}) & mask;
    end
  endtask

  // full stream: junk right, npairs frames, opening edge of a new left half
  task automatic run_stream(input logic [2:0] pin, input logic [2:0] rg,
                            input int half, input int npairs,
                            input bit check_pairs, input string tag);
    logic [2:0] f = pin | rg;
    logic lvl = (f == 3'd3) ? 1'b0 : 1'b1;
    gen_pairs(f);
    fmt_pin = pin; fmt_reg = rg;
    do_reset(~lvl);
    ncap = 0;
    play_half(f, ~lvl, 3, 24'h0);
    for (int p = 0; p < npairs; p++) begin
      play_half(f, lvl, half, exp_l[p]);
      play_half(f, ~lvl, half, exp_r[p]);
    end
    play_half(f, lvl, 2, 24'h0);
    repeat (4) @(negedge clk);
    if (check_pairs) begin
      chk({tag, " pair count"}, ncap, npairs);
      for (int p = 0; p < npairs && p < ncap; p++) begin
        chk({tag, " left"}, cap_l[p], exp_l[p]);
        chk({tag, " right"}, cap_r[p], exp_r[p]);
      end
    end
  endtask

  task automatic t_reset_r1;
    fmt_pin = 3'd0; fmt_reg = 3'd0;
    rst = 1'b1; repeat (3) @(negedge clk);
    chk("R1 left", left_sample, 0);
    chk("R1 right", right_sample, 0);
    chk("R1 valid", sample_valid, 0);
    chk("R1 err", clk_short_err, 0);
    rst = 1'b0; @(negedge clk);
    chk("R1 valid after release", sample_valid, 0);
  endtask

  task automatic t_lsb16_r3;  // also R8: filler ahead of word
    run_stream(3'd0, 3'd0, 32, 3, 1, "R3 R8 lsb16");
    chk("R3 err", clk_short_err, 0);
  endtask

  task automatic t_lsb20_r4;  // exactly 20 edges per half: no error
    run_stream(3'd1, 3'd0, 20, 2, 1, "R4 lsb20");
    chk("R4 R10 err at minimum", clk_short_err, 0);
  endtask

  task automatic t_lsb24_r5;
    run_stream(3'd0, 3'd4, 32, 2, 1, "R5 R8 lsb24");
  endtask

  task automatic t_msb24_r6;
    run_stream(3'd2, 3'd0, 32, 3, 1, "R6 msb24");
  endtask

  task automatic t_i2s_r7;
    run_stream(3'd3, 3'd0, 32, 2, 1, "R7 i2s");
  endtask

  task automatic t_or_r2;  // 001 | 010 -> I2S
    run_stream(3'd1, 3'd2, 32, 2, 1, "R2 or");
  endtask

  task automatic t_latency_r9;
    gen_pairs(3'd2);
    fmt_pin = 3'd2; fmt_reg = 3'd0;
    do_reset(1'b0);
    play_half(3'd2, 1'b0, 3, 24'h0);
    play_half(3'd2, 1'b1, 32, exp_l[0]);
    play_half(3'd2, 1'b0, 32, exp_r[0]);
    lrclk = 1'b1; sdata = 1'b0; bclk = 1'b0;
    repeat (2) @(negedge clk);
    bclk = 1'b1;
    @(negedge clk); chk("R9 valid +1", sample_valid, 0);
    @(negedge clk); chk("R9 valid +2", sample_valid, 0);
    @(negedge clk); chk("R9 valid +3", sample_valid, 1);
    chk("R9 left", left_sample, exp_l[0]);
    chk("R9 right", right_sample, exp_r[0]);
    @(negedge clk); chk("R9 valid +4", sample_valid, 0);
  endtask

  task automatic t_short_r10;
    run_stream(3'd4, 3'd0, 23, 1, 0, "R10");
    chk("R10 err 23 edges", clk_short_err, 1);
    play_half(3'd4, 1'b0, 32, 24'h0);
    play_half(3'd4, 1'b1, 2, 24'h0);
    repeat (4) @(negedge clk);
    chk("R10 err sticky", clk_short_err, 1);
    run_stream(3'd0, 3'd0, 15, 1, 0, "R10");
    chk("R10 err 15 edges", clk_short_err, 1);
    run_stream(3'd0, 3'd0, 16, 1, 1, "R10 16 edges");
    chk("R10 err at 16 edges", clk_short_err, 0);
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_lsb16_r3();
    t_lsb20_r4();
    t_lsb24_r5();
    t_msb24_r6();
    t_i2s_r7();
    t_or_r2();
    t_latency_r9();
    t_short_r10();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule